// File: doc/BRIEF.md
# Pipelined Converter Digit Correction

This block turns the raw decisions of a two-channel pipelined analog-to-digital converter into finished 10-bit sample words. Each channel has nine stages. The first eight stages are redundant: each resolves one and a half bits from two comparators and reports a digit of 0, 1 or 2. The ninth stage is a plain 2-bit flash that reports 0 to 3. A sample moves one stage forward every half clock, so the stages report their digits for the same sample at staggered clock cycles.

For every stage, the block holds that stage's digit in a deskew register chain until the last stage has spoken. It then merges the overlapping digits by shifted addition. This lets comparator offsets that stay inside the redundancy window cancel out, so no output code is skipped. Each stage reports its digit together with its own valid bit. A word is issued only when all nine digits of that sample were valid. A value of 3 from a redundant stage cannot occur in a healthy stage. The block clips it to 2 and flags it.

Top module: `pipe_adc_ec`

## Requirements
- R1: While reset is asserted, and until the first complete sample emerges after release, `word_o`, `word_vld_o` and `code_err_o` are all zero. Reset is asynchronous active-low and is released through two synchronizing flops.
- R2: Channel c, stage i (i = 0 is the most significant stage) reads its digit from `stg_code_i[(c*9+i)*2 +: 2]` and its valid bit from `stg_vld_i[c*9+i]`. For sample n, stage i's digit must be presented floor(i/2) clock cycles after stage 0's digit.
- R3: The word for a sample is on `word_o` with `word_vld_o` high just after the fifth rising edge that follows the edge capturing its stage-0 digit.
- R4: The issued word equals the sum over i = 0..7 of digit_i shifted left by (8 − i), plus the stage-8 digit. This ranges over 0 to 1023 without wrap.
- R5: Suppose a quantizer model uses full scale ±1024, stage thresholds at ±256, and each threshold shifted by up to 200 in either direction. Then every input code 0..1023 is reproduced exactly, so no code is missing.
- R6: The two channels are independent. Each channel's words depend only on its own digits and valid bits.
- R7: `word_vld_o` is high for a sample only if all nine of its stage valid bits were high. Otherwise `word_o` keeps its previous value, and digits presented with a low valid bit have no effect.
- R8: A digit of 3 from stages 0..7 is treated as 2, and `code_err_o` is high in the same cycle as the word it affected. A digit of 3 from stage 8 is legal and raises no flag. `code_err_o` is never high without `word_vld_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_code_i | input | NCH*(NBITS-1)*2 | Per-stage 2-bit digits, packed by channel then stage |
| stg_vld_i | input | NCH*(NBITS-1) | Per-stage digit valid bits |
| word_o | output | NCH*NBITS | Corrected word, channel c at bits [c*NBITS +: NBITS] |
| word_vld_o | output | NCH | A new word was issued this cycle |
| code_err_o | output | NCH | The issued word used an illegal redundant digit |

## Verification
The bench uses the defaults: two channels, a 10-bit word and two stages per clock. At this size the whole code range of 1024 values is swept on both channels, with channel B running the ramp in reverse. The sweep runs once with ideal thresholds and twice with a distinct offset on every comparator. A bench-side quantizer model produces the digits, so missing codes and misalignment would show up directly against the known input. Further passes sweep pseudo-random digit patterns that include illegal values, and valid gaps carrying junk digits. These passes reach the clipping, flagging and hold paths.

// File: rtl/adc_ec_pkg.sv
`timescale 1ns/1ps
package adc_ec_pkg;

  typedef logic [1:0] stg_code_t;

  // clock cycle at which stage idx sees a sample, relative to stage 0
  function automatic int stg_offset(input int idx, input int per_clk);
    return idx / per_clk;
  endfunction

  // registers needed so stage idx lines up one edge after the last stage
  function automatic int stg_depth(input int idx, input int nstg, input int per_clk);
    return (nstg - 1) / per_clk - idx / per_clk + 1;
  endfunction

endpackage

// File: rtl/ec_skew_line.sv
`timescale 1ns/1ps
module ec_skew_line
  import adc_ec_pkg::*;
#(
  parameter int DEPTH = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_vld,
  input  stg_code_t in_code,
  output logic      out_vld,
  output stg_code_t out_code
);

  logic [DEPTH-1:0]       v_q;
  logic [DEPTH-1:0]       v_d;
  logic [DEPTH-1:0][1:0]  c_q;
  logic [DEPTH-1:0][1:0]  c_d;

  // next state: valid always shifts, digit moves only behind a valid
  always_comb begin
    v_d[0] = in_vld;
    c_d[0] = in_vld ? in_code : c_q[0];
    for (int j = 1; j < DEPTH; j++) begin
      v_d[j] = v_q[j-1];
      c_d[j] = v_q[j-1] ? c_q[j-1] : c_q[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      c_q <= '0;
    end else begin
      v_q <= v_d;
      c_q <= c_d;
    end
  end

  assign out_vld  = v_q[DEPTH-1];
  assign out_code = c_q[DEPTH-1];

  AST_SKEW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (v_q[0] && c_q[0] == $past(in_code))); // R2

  generate
    if (DEPTH > 1) begin : g_shift_chk
      AST_SKEW_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[DEPTH-2] |=> (v_q[DEPTH-1] && c_q[DEPTH-1] == $past(c_q[DEPTH-2]))); // R3
    end
  endgenerate

endmodule

// File: rtl/ec_digit_sum.sv
`timescale 1ns/1ps
module ec_digit_sum #(
  parameter int NBITS = 10
) (
  input  logic [NBITS-2:0][1:0] digits,
  output logic [NBITS-1:0]      word,
  output logic                  bad
);

  localparam int NSTG = NBITS - 1;
  localparam int NRED = NSTG - 1;

  logic [NRED-1:0][1:0] legal;
  logic [NRED-1:0]      is_bad;

  generate
    for (genvar i = 0; i < NRED; i++) begin : g_clip
      assign is_bad[i] = (digits[i] == 2'd3);
      assign legal[i]  = is_bad[i] ? 2'd2 : digits[i];
    end
  endgenerate

  // overlapping shifted addition; maximum 2*(2^NBITS/2-2)+3 = 2^NBITS-1
  always_comb begin
    word = {{(NBITS-2){1'b0}}, digits[NSTG-1]};
    for (int i = 0; i < NRED; i++) begin
      word = word + ({{(NBITS-2){1'b0}}, legal[i]} << (NBITS - 2 - i));
    end
  end

  assign bad = |is_bad;

endmodule

// File: rtl/ec_channel.sv
`timescale 1ns/1ps
module ec_channel
  import adc_ec_pkg::*;
#(
  parameter int NBITS   = 10,
  parameter int PER_CLK = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(NBITS-1)*2-1:0] code_i,
  input  logic [NBITS-2:0]      vld_i,
  output logic [NBITS-1:0]      word_o,
  output logic                  vld_o,
  output logic                  err_o
);

  localparam int NSTG = NBITS - 1;

  logic [NSTG-1:0][1:0] al_code;
  logic [NSTG-1:0]      al_vld;

  generate
    for (genvar i = 0; i < NSTG; i++) begin : g_stage
      localparam int DEP = stg_depth(i, NSTG, PER_CLK);
      ec_skew_line #(.DEPTH(DEP)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (vld_i[i]),
        .in_code  (code_i[i*2 +: 2]),
        .out_vld  (al_vld[i]),
        .out_code (al_code[i])
      );
    end
  endgenerate

  logic             all_vld;
  logic [NBITS-1:0] sum_word;
  logic             sum_bad;

  assign all_vld = &al_vld;

  ec_digit_sum #(.NBITS(NBITS)) u_sum (
    .digits (al_code),
    .word   (sum_word),
    .bad    (sum_bad)
  );

  logic [NBITS-1:0] word_q, word_d;
  logic             vld_q, vld_d;
  logic             err_q, err_d;

  always_comb begin
    word_d = all_vld ? sum_word : word_q;
    vld_d  = all_vld;
    err_d  = all_vld & sum_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
      err_q  <= err_d;
    end
  end

  assign word_o = word_q;
  assign vld_o  = vld_q;
  assign err_o  = err_q;

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !all_vld |=> $stable(word_q)); // R7

  AST_ERR_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> vld_q); // R8

endmodule

// File: rtl/pipe_adc_ec.sv
`timescale 1ns/1ps
module pipe_adc_ec #(
  parameter int NCH     = 2,
  parameter int NBITS   = 10,
  parameter int PER_CLK = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCH*(NBITS-1)*2-1:0]   stg_code_i,
  input  logic [NCH*(NBITS-1)-1:0]     stg_vld_i,
  output logic [NCH*NBITS-1:0]         word_o,
  output logic [NCH-1:0]               word_vld_o,
  output logic [NCH-1:0]               code_err_o
);

  localparam int NSTG   = NBITS - 1;
  localparam int CODE_W = NSTG * 2;

  // asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      ec_channel #(.NBITS(NBITS), .PER_CLK(PER_CLK)) u_ch (
        .clk    (clk),
        .rst_n  (rst_sync_q),
        .code_i (stg_code_i[c*CODE_W +: CODE_W]),
        .vld_i  (stg_vld_i[c*NSTG +: NSTG]),
        .word_o (word_o[c*NBITS +: NBITS]),
        .vld_o  (word_vld_o[c]),
        .err_o  (code_err_o[c])
      );
    end
  endgenerate

endmodule

// File: tb/tb_pipe_adc_ec.sv
`timescale 1ns/1ps
module tb_pipe_adc_ec;

  localparam int NCH  = 2;
  localparam int NB   = 10;
  localparam int NS   = NB - 1;
  localparam int LAT  = 6;   // drive iteration to check iteration (5 edges)
  localparam int NMAX = 1024;

  logic                   clk;
  logic                   rst_n;
  logic [NCH*NS*2-1:0]    stg_code_i;
  logic [NCH*NS-1:0]      stg_vld_i;
  logic [NCH*NB-1:0]      word_o;
  logic [NCH-1:0]         word_vld_o;
  logic [NCH-1:0]         code_err_o;

  pipe_adc_ec dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .stg_code_i (stg_code_i),
    .stg_vld_i  (stg_vld_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .code_err_o (code_err_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int cd  [NCH][NMAX][NS];
  bit vl  [NCH][NMAX][NS];
  int ex_w[NCH][NMAX];
  bit ex_v[NCH][NMAX];
  bit ex_e[NCH][NMAX];
  int held[NCH];
  int seed = 32'h1d2c3b4a;

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32'h7fff;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // quantizer model: full scale +/-1024, thresholds +/-256 plus offsets
  task automatic quantize(input int ch, input int s, input int x, input int set);
    int r, lo, hi, c;
    r = 2 * x - 1023;
    for (int i = 0; i < NS - 1; i++) begin
      lo = -256;
      hi = 256;
      if (set != 0) begin
        lo = lo + ((i * 73 + set * 41 + ch * 29) % 401) - 200;
        hi = hi + ((i * 53 + set * 17 + ch * 31) % 401) - 200;
      end
      c = (r < lo) ? 0 : ((r >= hi) ? 2 : 1);
      cd[ch][s][i] = c;
      r = 2 * r - (c - 1) * 1024;
    end
    cd[ch][s][NS-1] = (r < -512) ? 0 : (r < 0) ? 1 : (r < 512) ? 2 : 3;
    for (int i = 0; i < NS; i++) vl[ch][s][i] = 1'b1;
    ex_w[ch][s] = x;
    ex_v[ch][s] = 1'b1;
    ex_e[ch][s] = 1'b0;
  endtask

  // expected word straight from digits, illegal redundant digit clipped
  task automatic expect_digits(input int ch, input int s);
    int acc;
    bit bad;
    acc = cd[ch][s][NS-1];
    bad = 1'b0;
    for (int i = 0; i < NS - 1; i++) begin
      if (cd[ch][s][i] == 3) bad = 1'b1;
      acc += ((cd[ch][s][i] == 3) ? 2 : cd[ch][s][i]) * (1 << (NB - 2 - i));
    end
    ex_w[ch][s] = acc;
    ex_v[ch][s] = 1'b1;
    ex_e[ch][s] = bad;
  endtask

  task automatic run_batch(input int n, input string tag);
    for (int t = 0; t < n + LAT; t++) begin
      @(negedge clk);
      for (int ch = 0; ch < NCH; ch++) begin
        for (int i = 0; i < NS; i++) begin
          int s;
          s = t - i / 2;
          if (s >= 0 && s < n) begin
            stg_code_i[(ch*NS+i)*2 +: 2] = 2'(cd[ch][s][i]);
            stg_vld_i[ch*NS+i]           = vl[ch][s][i];
          end else begin
            stg_code_i[(ch*NS+i)*2 +: 2] = 2'd0;
            stg_vld_i[ch*NS+i]           = 1'b0;
          end
        end
        if (t - LAT >= 0 && t - LAT < n) begin
          int s;
          string wt;
          s  = t - LAT;
          wt = (ch == 1) ? {tag, " R6"} : tag;
          if (ex_v[ch][s]) held[ch] = ex_w[ch][s];
          chk({wt, " word"}, int'(word_o[ch*NB +: NB]), held[ch]);
          chk("R7 R3 valid", int'(word_vld_o[ch]), int'(ex_v[ch][s]));
          chk("R8 flag", int'(code_err_o[ch]), int'(ex_e[ch][s]));
        end
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    stg_code_i = '0;
    stg_vld_i  = '0;
    held[0]    = 0;
    held[1]    = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet after reset
    chk("R1 word", int'(word_o), 0);
    chk("R1 valid", int'(word_vld_o), 0);
    chk("R1 flag", int'(code_err_o), 0);

    // ideal thresholds, full ramp, reverse ramp on channel 1
    for (int s = 0; s < NMAX; s++) begin
      quantize(0, s, s, 0);
      quantize(1, s, NMAX - 1 - s, 0);
    end
    run_batch(NMAX, "R2 R3 R4");

    // shifted comparator thresholds: no missing codes
    for (int set = 1; set <= 2; set++) begin
      for (int s = 0; s < NMAX; s++) begin
        quantize(0, s, s, set);
        quantize(1, s, NMAX - 1 - s, set + 2);
      end
      run_batch(NMAX, "R5");
    end

    // pseudo-random digits including illegal redundant 3s and last-stage 3s
    for (int s = 0; s < 600; s++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        for (int i = 0; i < NS; i++) begin
          int v;
          v = rnd() % 16;
          if (i == NS - 1) cd[ch][s][i] = v % 4;
          else             cd[ch][s][i] = (v == 0) ? 3 : v % 3;
          vl[ch][s][i] = 1'b1;
        end
        expect_digits(ch, s);
      end
    end
    run_batch(600, "R4 R8");

    // valid gaps carrying junk digits
    for (int s = 0; s < 500; s++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        quantize(ch, s, (s * 7 + ch * 300) % NMAX, 1);
        if ((s + ch * 2) % 7 == 3) begin
          int j;
          j = (s + ch) % NS;
          vl[ch][s][j] = 1'b0;
          cd[ch][s][j] = 3;
          ex_v[ch][s]  = 1'b0;
        end
      end
    end
    run_batch(500, "R7");

    // R1: reset mid-stream clears outputs at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 word async", int'(word_o), 0);
    chk("R1 valid async", int'(word_vld_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 word release", int'(word_o), 0);
    chk("R1 flag release", int'(code_err_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule